// File: doc/BRIEF.md
# Descriptor-Ring Audio Playback DMA

This block is a bus-master playback engine for a single audio output. Software fills a ring of 32 eight-byte buffer descriptors in memory, points the engine at the ring, moves a last-valid index forward as it adds entries, and sets the run bit. The engine reads each descriptor, fetches the sample buffer it names as 32-bit words, and streams 16-bit samples out on a valid/ready interface towards the codec link.

When an entry has been fully streamed, the current index steps forward modulo 32. Per-entry flags can request a completion event or force a stop. The engine stops by itself after consuming the last-valid entry. Sticky status bits record a stop at the last entry, a completed flagged entry, and an underrun of the internal sample queue. An interrupt line combines these with their enables. Software reaches everything through three 32-bit words with byte-lane strobes.

Top module: `audio_ring_dma`

## Requirements
- R1: After rst_n is released, word 0x0 reads 0, word 0x4 reads 0x00010000 (only the halted bit set), word 0x8 reads 0x00010000 (next index 1), and irq, mem_req and smp_valid are low.
- R2: For entry i the engine issues two 32-bit reads, first at base+8*i and then at base+8*i+4. The first word is the buffer address. The second word holds the sample count in bits 15:0 and the flags in bits 31:16. mem_req and mem_addr hold steady until mem_ack.
- R3: Sample data is read as 32-bit words, starting at the buffer address and going up by 4. The low half of each word goes out before the high half. An odd count uses only the low half of the final word. A count of zero produces no samples. smp_data stays stable while smp_valid is high and smp_ready is low.
- R4: Once all of an entry's samples are accepted, the current index (byte 0x04) steps by one modulo 32. Byte 0x0A reads that index plus one modulo 32. Bytes 0x08-0x09 count the samples accepted from the current entry, and this count restarts at 0 for each new entry.
- R5: When the finished entry equals the last-valid index (byte 0x05, 5 bits), or its flags have bit 14 set, status bit 2 is set, control bit 0 (run) is cleared, and the engine halts.
- R6: Finishing an entry whose flags have bit 15 set sets status bit 3, whatever the interrupt enables are.
- R7: When run is 1, smp_ready is high and no sample is queued, status bit 4 is set. Playback then carries on and delivers every sample.
- R8: Status bits 2, 3 and 4 (bytes 0x06-0x07) clear when 1 is written to them. Writing 0 leaves them unchanged. Bit 0 is read-only.
- R9: irq is high exactly when some status bit k in {2,3,4} is set together with control bit k (2 last-entry, 3 completion, 4 underrun enable).
- R10: With run 0, no new memory read starts and smp_valid is low. Status bit 0 reads 1 once no read is outstanding. Setting run again resumes the same entry where it stopped.
- R11: Writing 1 to control bit 1 clears the whole register box once no read is outstanding. The bit then reads 0 again.
- R12: Word 0x0 is the ring base address, writable per byte. The current-index byte, the count bytes and the next-index byte are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address; bits 3:2 select the word |
| reg_wdata | input | 32 | Write data, little-endian byte lanes |
| reg_wstrb | input | 4 | Byte-lane enables for writes |
| reg_rdata | output | 32 | Read data of the selected word |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read completion; mem_rdata valid |
| mem_rdata | input | 32 | Read data |
| smp_valid | output | 1 | Sample available |
| smp_data | output | 16 | Sample value |
| smp_ready | input | 1 | Sink accepts the sample |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that memory answers each request with exactly one single-cycle mem_ack, and never raises mem_ack without a request. They also assume that software does not write the run bit in the same cycle as a stop. The bench's memory model acknowledges only pending requests, after a random latency of 0 to 3 cycles. Register writes come only from directed tasks at known idle points. Except in the underrun scenario, the sink raises smp_ready only while smp_valid is high, so no underrun appears where none is expected.

// File: rtl/audio_ring_dma.sv
module audio_ring_dma #(
  parameter int RING_LEN   = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [3:0]  reg_wstrb,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        smp_valid,
  output logic [15:0] smp_data,
  input  logic        smp_ready,
  output logic        irq
);
  localparam int IW = $clog2(RING_LEN);
  localparam int FW = $clog2(FIFO_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_D0, S_D1, S_DATA} st_t;

  st_t          st_q;
  logic [31:0]  base_q, buf_q;
  logic [IW-1:0] cur_q, last_q, next_idx;
  logic         sts_last, sts_ioc, sts_ferr;
  logic         run_q, rst_q, en_last, en_ioc, en_ferr;
  logic [15:0]  xfer_q, cnt_q, left_q;
  logic         flg_stop, flg_ioc;
  logic [15:0]  fifo_q [FIFO_DEPTH];
  logic [FW-1:0] wp_q, rp_q, wp_nx;
  logic [FW:0]  fcnt_q, push_n;

  logic halted, box_clr, pop, push, push_two, finish, stop_now, issue, underrun;
  logic w0, w1, w2;
  logic [31:0] issue_addr;
  logic [15:0] status;
  logic [7:0]  ctrl;

  assign halted   = !run_q && !mem_req;
  assign status   = {11'd0, sts_ferr, sts_ioc, sts_last, 1'b0, halted};
  assign ctrl     = {3'd0, en_ferr, en_ioc, en_last, rst_q, run_q};
  assign next_idx = cur_q + 1'b1;

  always_comb begin
    case (reg_addr[3:2])
      2'd0:    reg_rdata = base_q;
      2'd1:    reg_rdata = {status, 8'(last_q), 8'(cur_q)};
      2'd2:    reg_rdata = {ctrl, 8'(next_idx), xfer_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  assign w0 = reg_we && reg_addr[3:2] == 2'd0;
  assign w1 = reg_we && reg_addr[3:2] == 2'd1;
  assign w2 = reg_we && reg_addr[3:2] == 2'd2;

  assign smp_valid = run_q && fcnt_q != '0;
  assign smp_data  = fifo_q[rp_q];
  assign pop       = smp_valid && smp_ready;
  assign push      = st_q == S_DATA && mem_ack;
  assign push_two  = left_q > 16'd1;
  assign push_n    = push ? (push_two ? (FW+1)'(2) : (FW+1)'(1)) : '0;
  assign wp_nx     = wp_q + 1'b1;

  assign box_clr  = rst_q && (!mem_req || mem_ack);
  assign finish   = st_q == S_DATA && run_q && !rst_q && xfer_q == cnt_q;
  assign stop_now = finish && (cur_q == last_q || flg_stop);
  assign underrun = run_q && !rst_q && smp_ready && fcnt_q == '0;

  assign issue = !mem_req && run_q && !rst_q &&
                 (st_q == S_D0 || st_q == S_D1 ||
                  (st_q == S_DATA && left_q != 16'd0 && fcnt_q <= (FW+1)'(FIFO_DEPTH - 2)));

  always_comb begin
    if (st_q == S_DATA) issue_addr = buf_q;
    else issue_addr = base_q + 32'({cur_q, 3'b000}) + (st_q == S_D1 ? 32'd4 : 32'd0);
  end

  assign irq = (sts_last && en_last) || (sts_ioc && en_ioc) || (sts_ferr && en_ferr);

  always_ff @(posedge clk) begin
    if (push) begin
      fifo_q[wp_q] <= mem_rdata[15:0];
      if (push_two) fifo_q[wp_nx] <= mem_rdata[31:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; base_q <= '0; buf_q <= '0; cur_q <= '0; last_q <= '0;
      sts_last <= 1'b0; sts_ioc <= 1'b0; sts_ferr <= 1'b0;
      run_q <= 1'b0; rst_q <= 1'b0; en_last <= 1'b0; en_ioc <= 1'b0; en_ferr <= 1'b0;
      xfer_q <= '0; cnt_q <= '0; left_q <= '0; flg_stop <= 1'b0; flg_ioc <= 1'b0;
      wp_q <= '0; rp_q <= '0; fcnt_q <= '0; mem_req <= 1'b0; mem_addr <= '0;
    end else if (box_clr) begin
      st_q <= S_IDLE; base_q <= '0; buf_q <= '0; cur_q <= '0; last_q <= '0;
      sts_last <= 1'b0; sts_ioc <= 1'b0; sts_ferr <= 1'b0;
      run_q <= 1'b0; rst_q <= 1'b0; en_last <= 1'b0; en_ioc <= 1'b0; en_ferr <= 1'b0;
      xfer_q <= '0; cnt_q <= '0; left_q <= '0; flg_stop <= 1'b0; flg_ioc <= 1'b0;
      wp_q <= '0; rp_q <= '0; fcnt_q <= '0; mem_req <= 1'b0; mem_addr <= '0;
    end else begin
      for (int i = 0; i < 4; i++)
        if (w0 && reg_wstrb[i]) base_q[8*i +: 8] <= reg_wdata[8*i +: 8];
      if (w1 && reg_wstrb[1]) last_q <= reg_wdata[8 +: IW];

      sts_last <= (sts_last && !(w1 && reg_wstrb[2] && reg_wdata[18])) || stop_now;
      sts_ioc  <= (sts_ioc  && !(w1 && reg_wstrb[2] && reg_wdata[19])) || (finish && flg_ioc);
      sts_ferr <= (sts_ferr && !(w1 && reg_wstrb[2] && reg_wdata[20])) || underrun;

      if (w2 && reg_wstrb[3]) begin
        run_q   <= reg_wdata[24];
        rst_q   <= rst_q || reg_wdata[25];
        en_last <= reg_wdata[26];
        en_ioc  <= reg_wdata[27];
        en_ferr <= reg_wdata[28];
      end
      if (stop_now) run_q <= 1'b0;

      if (issue) begin
        mem_req  <= 1'b1;
        mem_addr <= issue_addr;
      end else if (mem_ack) begin
        mem_req <= 1'b0;
      end

      if (push) wp_q <= push_two ? wp_q + 2'd2 : wp_nx;
      if (pop)  rp_q <= rp_q + 1'b1;
      fcnt_q <= fcnt_q + push_n - (FW+1)'(pop);

      case (st_q)
        S_IDLE: if (run_q && !rst_q) st_q <= S_D0;
        S_D0: if (mem_ack) begin
          buf_q <= mem_rdata;
          st_q  <= S_D1;
        end
        S_D1: if (mem_ack) begin
          cnt_q    <= mem_rdata[15:0];
          left_q   <= mem_rdata[15:0];
          flg_stop <= mem_rdata[30];
          flg_ioc  <= mem_rdata[31];
          xfer_q   <= '0;
          st_q     <= S_DATA;
        end
        default: begin
          if (push) begin
            buf_q  <= buf_q + 32'd4;
            left_q <= left_q - (push_two ? 16'd2 : 16'd1);
          end
          if (pop) xfer_q <= xfer_q + 16'd1;
          if (finish) begin
            cur_q <= next_idx;
            st_q  <= stop_now ? S_IDLE : S_D0;
          end
        end
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_smp_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready && !stop_now && !box_clr && !(w2 && reg_wstrb[3])
      |=> smp_valid && $stable(smp_data));

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(box_clr) && cur_q != $past(cur_q) |-> cur_q == $past(cur_q) + 1'b1);

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> !run_q && sts_last);

  p_ioc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finish && flg_ioc |=> sts_ioc);

  p_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !mem_req |=> !mem_req);

  p_rst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q && !mem_req |=> !rst_q && cur_q == '0);
endmodule

// File: tb/audio_ring_dma_tb.sv
module audio_ring_dma_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0, reg_wstrb = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic smp_valid, smp_ready = 1'b0;
  logic [15:0] smp_data;
  logic irq;

  audio_ring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [4096];
  logic [15:0] exp_q[$], got_q[$];
  logic [31:0] req_log[$];
  int nchk = 0, nfail = 0;
  bit gate_ready = 1'b1;
  int ready_pct = 70;

  initial begin : responder
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat == 0) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr[13:2]];
          req_log.push_back(mem_addr);
          lat = $urandom % 4;
        end else lat--;
      end
    end
  end

  initial begin : sink
    forever begin
      @(negedge clk);
      if (gate_ready) smp_ready = smp_valid && (($urandom % 100) < ready_pct);
      else smp_ready = (($urandom % 100) < ready_pct);
      if (smp_valid && smp_ready) got_q.push_back(smp_data);
    end
  end

  function automatic logic [31:0] buf_of(int idx);
    return 32'h2000 + 32'(idx) * 32'h100;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wstrb = s; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wstrb = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_desc(int idx, int cnt, logic [15:0] flg);
    logic [31:0] b, w;
    b = buf_of(idx);
    mem[(BASE >> 2) + 32'(idx) * 2]     = b;
    mem[(BASE >> 2) + 32'(idx) * 2 + 1] = {flg, 16'(cnt)};
    for (int k = 0; k < (cnt + 1) / 2; k++) mem[(b >> 2) + 32'(k)] = $urandom;
    for (int k = 0; k < cnt; k++) begin
      w = mem[(b >> 2) + 32'(k / 2)];
      exp_q.push_back((k % 2) ? w[31:16] : w[15:0]);
    end
  endtask

  task automatic wait_halt(string tag, int maxc);
    logic [31:0] w;
    bit done;
    done = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < maxc && !done; i++) begin
      rd(4'h4, w);
      if (w[16]) done = 1'b1;
    end
    nchk++;
    if (!done) begin
      nfail++;
      $display("FAIL %s: actual not halted expected halted", tag);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp(string tag);
    int bad;
    bad = -1;
    nchk++;
    if (got_q.size() == exp_q.size()) begin
      foreach (exp_q[i]) if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    end
    if (got_q.size() != exp_q.size()) begin
      nfail++;
      $display("FAIL %s: actual %0d samples expected %0d", tag, got_q.size(), exp_q.size());
    end else if (bad >= 0) begin
      nfail++;
      $display("FAIL %s: sample %0d actual %04h expected %04h", tag, bad, got_q[bad], exp_q[bad]);
    end
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] w;
    int c4, c3, n, r;
    void'($urandom(32'd4242));
    foreach (mem[i]) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd(4'h0, w); chk("R1 base", w, 32'h0);
    rd(4'h4, w); chk("R1 word4", w, 32'h0001_0000);
    rd(4'h8, w); chk("R1 word8", w, 32'h0001_0000);
    chk("R1 irq/req/valid", {irq, mem_req, smp_valid}, 32'h0);

    // R2 R3 R4 R6 R5 R9: five entries, one empty, one flagged for completion
    wr(4'h0, BASE, 4'hF);
    rd(4'h0, w); chk("R12 base write", w, BASE);
    wr(4'h4, 32'h0000_0400, 4'b0010);
    c4 = 1 + $urandom % 12;
    set_desc(0, 5, 16'h0);
    set_desc(1, 8, 16'h8000);
    set_desc(2, 0, 16'h0);
    set_desc(3, 7, 16'h0);
    set_desc(4, c4, 16'h0);
    req_log.delete();
    wr(4'h8, 32'h0D00_0000, 4'h8);
    wait_halt("R5 halt at last", 2000);
    chk("R2 first desc read", req_log[0], BASE);
    chk("R2 second desc read", req_log[1], BASE + 32'd4);
    chk("R3 first data read", req_log[2], buf_of(0));
    cmp("R3 sample stream");
    rd(4'h4, w); chk("R4 R5 R6 word4", w, {16'h000D, 8'h04, 8'h05});
    rd(4'h8, w); chk("R4 word8", w, {8'h0C, 8'h06, 16'(c4)});
    chk("R9 irq set", 32'(irq), 32'h1);

    // R8 R12: write-one-to-clear, read-only index
    wr(4'h4, 32'h0004_00FF, 4'b0101);
    rd(4'h4, w); chk("R8 R12 clear bit2", w, {16'h0009, 8'h04, 8'h05});
    chk("R9 irq completion", 32'(irq), 32'h1);
    wr(4'h4, 32'h0000_0000, 4'b1100);
    rd(4'h4, w); chk("R8 write zero", w, {16'h0009, 8'h04, 8'h05});
    wr(4'h4, 32'h0008_0000, 4'b0100);
    rd(4'h4, w); chk("R8 clear bit3", w, {16'h0001, 8'h04, 8'h05});
    chk("R9 irq clear", 32'(irq), 32'h0);

    // R5 stop flag before last index, enables off
    set_desc(5, 3, 16'h0);
    set_desc(6, 4, 16'h0);
    set_desc(7, 2, 16'hC000);
    wr(4'h4, 32'h0000_1400, 4'b0010);
    wr(4'h8, 32'h0100_0000, 4'h8);
    wait_halt("R5 stop flag", 2000);
    cmp("R3 stop stream");
    rd(4'h4, w); chk("R5 stop flag word4", w, {16'h000D, 8'h14, 8'h08});
    chk("R9 irq masked", 32'(irq), 32'h0);
    wr(4'h4, 32'h001C_0000, 4'b0100);

    // R4 wrap across index 31 with random counts
    ready_pct = 50;
    c3 = 0;
    for (int i = 8; i < 36; i++) begin
      r = $urandom % 7;
      set_desc(i % 32, r, 16'h0);
      if (i == 35) c3 = r;
    end
    wr(4'h4, 32'h0000_0300, 4'b0010);
    wr(4'h8, 32'h0500_0000, 4'h8);
    wait_halt("R4 wrap halt", 5000);
    cmp("R4 wrap stream");
    rd(4'h4, w); chk("R4 wrap word4", w, {16'h0005, 8'h03, 8'h04});
    rd(4'h8, w); chk("R4 wrap word8", w, {8'h04, 8'h05, 16'(c3)});
    wr(4'h4, 32'h001C_0000, 4'b0100);

    // R10 pause and resume
    ready_pct = 70;
    set_desc(4, 20, 16'h0);
    set_desc(5, 20, 16'h0);
    set_desc(6, 20, 16'h0);
    wr(4'h4, 32'h0000_0600, 4'b0010);
    wr(4'h8, 32'h0100_0000, 4'h8);
    repeat (25) @(negedge clk);
    wr(4'h8, 32'h0000_0000, 4'h8);
    repeat (8) @(negedge clk);
    chk("R10 paused outputs", {smp_valid, mem_req}, 32'h0);
    rd(4'h4, w); chk("R10 halted bit", 32'(w[16]), 32'h1);
    n = got_q.size();
    r = req_log.size();
    repeat (20) @(negedge clk);
    chk("R10 no samples while paused", 32'(got_q.size()), 32'(n));
    chk("R10 no reads while paused", 32'(req_log.size()), 32'(r));
    wr(4'h8, 32'h0100_0000, 4'h8);
    wait_halt("R10 resume halt", 3000);
    cmp("R10 resumed stream");
    rd(4'h4, w); chk("R10 final index", w, {16'h0005, 8'h06, 8'h07});
    wr(4'h4, 32'h001C_0000, 4'b0100);

    // R7 underrun: sink always ready
    gate_ready = 1'b0;
    ready_pct = 100;
    set_desc(7, 6, 16'h0);
    set_desc(8, 6, 16'h0);
    wr(4'h4, 32'h0000_0800, 4'b0010);
    wr(4'h8, 32'h1100_0000, 4'h8);
    wait_halt("R7 halt", 2000);
    gate_ready = 1'b1;
    cmp("R7 stream continues");
    rd(4'h4, w); chk("R7 underrun status", 32'(w[31:16]), 32'h0015);
    chk("R9 irq underrun", 32'(irq), 32'h1);
    wr(4'h4, 32'h0010_0000, 4'b0100);
    rd(4'h4, w); chk("R8 clear bit4", 32'(w[31:16]), 32'h0005);
    chk("R9 irq after clear", 32'(irq), 32'h0);

    // R11 box reset
    wr(4'h8, 32'h0200_0000, 4'h8);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      rd(4'h8, w);
      if (!w[25] && n == 0) n = 1;
    end
    chk("R11 bit self-clears", 32'(n), 32'h1);
    rd(4'h0, w); chk("R11 base cleared", w, 32'h0);
    rd(4'h4, w); chk("R11 word4 cleared", w, 32'h0001_0000);
    rd(4'h8, w); chk("R11 word8 cleared", w, 32'h0001_0000);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule